// File: doc/BRIEF.md
# Critical-Word-First Line Refill Unit

This block serves loads for a small set-associative data cache and, on a miss, refills one line from a 64-bit pipelined memory bus. It does not fetch the line from row zero. It first asks for the doubleword the missing load wants, then wraps around through the remaining rows of the line. Each returned beat is written into a row-addressed data RAM, and a per-row valid bit is set for it. The missed doubleword is also sent straight to the load result from the bus beat, without a read of the RAM.

Loads enter a single holding stage. A load that hits a resident line returns its data from the RAM. A load to the line that is being refilled waits only until its own row has arrived. A load that misses on another line waits until the current refill has finished, and then starts its own refill. The victim way is a plain input that is sampled when a refill begins. The line tag is marked valid only once the whole line is in the RAM.

Top module: `cwf_line_refill`

## Requirements
- R1: During reset and right after it, wb_cyc_o and wb_stb_o are low, resp_valid_o is low and req_ready_o is high.
- R2: A load byte address splits into byte offset [2:0], row [5:3], set [7:6] and tag [15:8]. wb_adr_o is the doubleword address (byte address bits [15:3]). A miss issues exactly 8 read requests to its line. The first request is for the missed row, and request i is for row (start + i) mod 8. wb_cyc_o stays high until the 8th ack.
- R3: While wb_stb_o and wb_stall_i are both high, wb_stb_o stays high and wb_adr_o holds its value into the next cycle.
- R4: The missing load responds in the cycle right after the ack of its doubleword. resp_data_o equals that beat, and resp_addr_o equals the load's byte address.
- R5: A later load to the line being refilled responds one cycle after its row's valid bit is set, which is two cycles after that row's ack, even before the last beat. It causes no extra bus request.
- R6: A load to a fully resident line responds in the second cycle after it is accepted, with the stored doubleword, and causes no bus activity.
- R7: A load that misses on a different line while a refill is running waits. Its own refill starts only after the running one has received its last ack. The row-valid bits clear at the start of each refill.
- R8: A refill replaces only the way given by victim_way_i at its start. The line in the other way of the same set keeps hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Holding stage can take a load |
| req_addr_i | input | 16 | Load byte address |
| victim_way_i | input | 1 | Way to replace when a refill starts |
| resp_valid_o | output | 1 | Load result valid |
| resp_addr_o | output | 16 | Byte address of the completed load |
| resp_data_o | output | 64 | Load result doubleword |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus read request strobe |
| wb_adr_o | output | 13 | Bus doubleword address |
| wb_stall_i | input | 1 | Bus cannot take the request this cycle |
| wb_ack_i | input | 1 | Bus returns one beat |
| wb_dat_i | input | 64 | Bus read data |

## Verification
If the row-valid bits are wrong, a load to the refilling line returns one cycle too early with memory data it has not yet received, or it returns late. Either error shows up at resp_valid_o within two cycles of the relevant ack. A wrong wrap counter or start row shows on wb_adr_o at the very first or the next request of a refill. A stale tag or way choice shows up as either bus traffic on a load that should hit, or a wrong resp_data_o on the first load after the replacement. The bench runs a miss and a full hit sweep for every start row, pairs each refill with a follower load at every row distance, and checks each response cycle against the logged ack cycles.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int BUS_DW     = 64;
  localparam int BYTE_OFF_W = $clog2(BUS_DW / 8);
endpackage

// File: rtl/cwf_data_ram.sv
module cwf_data_ram #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cwf_tag_store.sv
module cwf_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [$clog2(SETS)-1:0]               lk_set_i,
  input  logic [TAG_W-1:0]                      lk_tag_i,
  output logic                                  hit_o,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  hit_way_o,
  input  logic                                  inv_i,
  input  logic [$clog2(SETS)-1:0]               inv_set_i,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  inv_way_i,
  input  logic                                  fill_i,
  input  logic [$clog2(SETS)-1:0]               fill_set_i,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0]  fill_way_i,
  input  logic [TAG_W-1:0]                      fill_tag_i
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (inv_i)  vld_q[inv_set_i][inv_way_i]   <= 1'b0;
      if (fill_i) vld_q[fill_set_i][fill_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[fill_set_i][fill_way_i] <= fill_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match;

  // R8: a line is never resident in two ways
  a_r8_single_way_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl #(
  parameter int ROWS   = 8,
  parameter int LINE_W = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [LINE_W-1:0]          start_line_i,
  input  logic [$clog2(ROWS)-1:0]    start_row_i,
  output logic                       wb_cyc_o,
  output logic                       wb_stb_o,
  output logic [LINE_W+$clog2(ROWS)-1:0] wb_adr_o,
  input  logic                       wb_stall_i,
  input  logic                       wb_ack_i,
  output logic                       active_o,
  output logic [LINE_W-1:0]          line_o,
  output logic [ROWS-1:0]            row_valid_o,
  output logic                       beat_we_o,
  output logic [$clog2(ROWS)-1:0]    beat_row_o,
  output logic                       crit_o,
  output logic                       last_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = ROW_W + 1;

  logic              active_q;
  logic [LINE_W-1:0] line_q;
  logic [ROW_W-1:0]  start_q;
  logic [CNT_W-1:0]  issue_q, ack_q;
  logic [ROWS-1:0]   valid_q;
  logic [ROW_W-1:0]  issue_row;
  logic              beat;

  assign issue_row  = start_q + issue_q[ROW_W-1:0];
  assign beat_row_o = start_q + ack_q[ROW_W-1:0];
  assign wb_cyc_o   = active_q;
  assign wb_stb_o   = active_q && (issue_q != CNT_W'(ROWS));
  assign wb_adr_o   = {line_q, issue_row};
  assign beat       = active_q && wb_ack_i;
  assign beat_we_o  = beat;
  assign crit_o     = beat && (ack_q == '0);
  assign last_o     = beat && (ack_q == CNT_W'(ROWS - 1));
  assign active_o   = active_q;
  assign line_o     = line_q;
  assign row_valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      line_q   <= '0;
      start_q  <= '0;
      issue_q  <= '0;
      ack_q    <= '0;
      valid_q  <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      line_q   <= start_line_i;
      start_q  <= start_row_i;
      issue_q  <= '0;
      ack_q    <= '0;
      valid_q  <= '0;
    end else begin
      if (wb_stb_o && !wb_stall_i) issue_q <= issue_q + 1'b1;
      if (beat) begin
        ack_q               <= ack_q + 1'b1;
        valid_q[beat_row_o] <= 1'b1;
      end
      if (last_o) active_q <= 1'b0;
    end
  end

  // R3: a stalled request is held unchanged
  a_r3_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_stb_o && wb_stall_i) |=> (wb_stb_o && $stable(wb_adr_o)));

  // R2: every ack answers a request already issued
  a_r2_ack_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && wb_ack_i) |-> (ack_q < issue_q));

  // R5: row-valid bits only grow during one refill
  a_r5_valid_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> ((valid_q & $past(valid_q)) == $past(valid_q)));
endmodule

// File: rtl/cwf_line_refill.sv
module cwf_line_refill
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROWS   = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 req_valid_i,
  output logic                                 req_ready_o,
  input  logic [ADDR_W-1:0]                    req_addr_i,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] victim_way_i,
  output logic                                 resp_valid_o,
  output logic [ADDR_W-1:0]                    resp_addr_o,
  output logic [BUS_DW-1:0]                    resp_data_o,
  output logic                                 wb_cyc_o,
  output logic                                 wb_stb_o,
  output logic [ADDR_W-BYTE_OFF_W-1:0]         wb_adr_o,
  input  logic                                 wb_stall_i,
  input  logic                                 wb_ack_i,
  input  logic [BUS_DW-1:0]                    wb_dat_i
);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - BYTE_OFF_W - ROW_W - SET_W;
  localparam int LINE_W = TAG_W + SET_W;
  localparam int RAM_AW = WAY_W + SET_W + ROW_W;

  // holding stage
  logic              s0_valid_q;
  logic [ADDR_W-1:0] s0_addr_q;
  logic [ROW_W-1:0]  s0_row;
  logic [SET_W-1:0]  s0_set;
  logic [TAG_W-1:0]  s0_tag;
  logic [LINE_W-1:0] s0_line;

  assign s0_row  = s0_addr_q[BYTE_OFF_W +: ROW_W];
  assign s0_set  = s0_addr_q[BYTE_OFF_W + ROW_W +: SET_W];
  assign s0_tag  = s0_addr_q[ADDR_W-1 -: TAG_W];
  assign s0_line = s0_addr_q[ADDR_W-1 -: LINE_W];

  // refill side
  logic              rf_active, rf_we, rf_crit, rf_last;
  logic [LINE_W-1:0] rf_line;
  logic [ROWS-1:0]   rf_row_valid;
  logic [ROW_W-1:0]  rf_beat_row;
  logic [SET_W-1:0]  rf_set;
  logic [TAG_W-1:0]  rf_tag;
  logic [WAY_W-1:0]  rf_way_q;
  logic              miss_pend_q;
  logic [ADDR_W-1:0] miss_addr_q;

  assign rf_set = rf_line[SET_W-1:0];
  assign rf_tag = rf_line[LINE_W-1 -: TAG_W];

  // lookup
  logic              lk_hit;
  logic [WAY_W-1:0]  lk_way;
  logic              in_line, s0_done, s0_miss, accept;
  logic [WAY_W-1:0]  rd_way;
  logic [BUS_DW-1:0] ram_rdata;

  assign in_line = rf_active && (rf_line == s0_line);
  assign s0_done = s0_valid_q && !rf_crit &&
                   (in_line ? rf_row_valid[s0_row] : lk_hit);
  assign s0_miss = s0_valid_q && !in_line && !lk_hit && !rf_active && !miss_pend_q;
  assign req_ready_o = !s0_valid_q || s0_done || s0_miss;
  assign accept      = req_valid_i && req_ready_o;
  assign rd_way      = in_line ? rf_way_q : lk_way;

  cwf_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (s0_set),
    .lk_tag_i   (s0_tag),
    .hit_o      (lk_hit),
    .hit_way_o  (lk_way),
    .inv_i      (s0_miss),
    .inv_set_i  (s0_set),
    .inv_way_i  (victim_way_i),
    .fill_i     (rf_last),
    .fill_set_i (rf_set),
    .fill_way_i (rf_way_q),
    .fill_tag_i (rf_tag)
  );

  cwf_refill_ctrl #(.ROWS(ROWS), .LINE_W(LINE_W)) u_refill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (s0_miss),
    .start_line_i (s0_line),
    .start_row_i  (s0_row),
    .wb_cyc_o     (wb_cyc_o),
    .wb_stb_o     (wb_stb_o),
    .wb_adr_o     (wb_adr_o),
    .wb_stall_i   (wb_stall_i),
    .wb_ack_i     (wb_ack_i),
    .active_o     (rf_active),
    .line_o       (rf_line),
    .row_valid_o  (rf_row_valid),
    .beat_we_o    (rf_we),
    .beat_row_o   (rf_beat_row),
    .crit_o       (rf_crit),
    .last_o       (rf_last)
  );

  cwf_data_ram #(.AW(RAM_AW), .DW(BUS_DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (rf_we),
    .waddr_i ({rf_way_q, rf_set, rf_beat_row}),
    .wdata_i (wb_dat_i),
    .raddr_i ({rd_way, s0_set, s0_row}),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_valid_q <= 1'b0;
      s0_addr_q  <= '0;
    end else if (accept) begin
      s0_valid_q <= 1'b1;
      s0_addr_q  <= req_addr_i;
    end else if (s0_done || s0_miss) begin
      s0_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_way_q    <= '0;
      miss_pend_q <= 1'b0;
      miss_addr_q <= '0;
    end else if (s0_miss) begin
      rf_way_q    <= victim_way_i;
      miss_pend_q <= 1'b1;
      miss_addr_q <= s0_addr_q;
    end else if (rf_crit) begin
      miss_pend_q <= 1'b0;
    end
  end

  // critical beat wins the result port; a waiting load retries next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_addr_o  <= '0;
      resp_data_o  <= '0;
    end else if (rf_crit) begin
      resp_valid_o <= 1'b1;
      resp_addr_o  <= miss_addr_q;
      resp_data_o  <= wb_dat_i;
    end else if (s0_done) begin
      resp_valid_o <= 1'b1;
      resp_addr_o  <= s0_addr_q;
      resp_data_o  <= ram_rdata;
    end else begin
      resp_valid_o <= 1'b0;
    end
  end

  // R2: first request of a refill targets the missed row
  a_r2_first_req_missed_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s0_miss |=> (wb_stb_o && (wb_adr_o[ROW_W-1:0] == $past(s0_row))));

  // R4: missed load completes the cycle after its beat
  a_r4_forward_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_crit |=> (resp_valid_o && (resp_addr_o == $past(miss_addr_q))));

  // R8: the way being refilled never reports a hit
  a_r8_refill_way_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_active && lk_hit && (s0_set == rf_set)) |-> (lk_way != rf_way_q));
endmodule

// File: tb/tb_cwf_line_refill.sv
`timescale 1ns/1ps
module tb_cwf_line_refill;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_addr_i = '0;
  logic [0:0]  victim_way_i = '0;
  logic        resp_valid_o;
  logic [15:0] resp_addr_o;
  logic [63:0] resp_data_o;
  logic        wb_cyc_o, wb_stb_o;
  logic [12:0] wb_adr_o;
  logic        wb_stall_i = 1'b0;
  logic        wb_ack_i = 1'b0;
  logic [63:0] wb_dat_i = '0;

  cwf_line_refill dut (.*);

  always #5 clk_i = ~clk_i;

  int cyc_n = 0;
  always @(posedge clk_i) cyc_n <= cyc_n + 1;

  int checks = 0, errors = 0;
  bit stall_en = 0, gap_en = 0;

  logic [12:0] fq[$];
  int          ack_log [0:1023];
  int          push_cyc[0:1023];
  logic [12:0] push_adr[0:1023];
  int          resp_cyc[0:511];
  logic [15:0] resp_adr[0:511];
  int n_push = 0, n_pop = 0, n_resp = 0;
  bit snap_ack = 0, snap_push = 0, snap_hold = 0;
  logic [12:0] snap_adr = '0;
  logic [9:0]  grp_line = '0;
  logic [2:0]  grp_start = '0;

  function automatic logic [63:0] memf(logic [12:0] a);
    logic [15:0] w = {3'b0, a};
    return {16'hC0DE, w, ~w, 16'(w * 16'd7)};
  endfunction

  function automatic logic [15:0] mk(int tag, int set, int row, int off);
    return {8'(tag), 2'(set), 3'(row), 3'(off)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one step per falling edge
  task automatic bus_step();
    if (rst_ni) begin
      if (snap_ack) begin
        ack_log[n_pop] = cyc_n;
        n_pop++;
        void'(fq.pop_front());
      end
      if (snap_hold) begin
        chk("R3 stb held", {63'b0, wb_stb_o}, 64'd1);
        chk("R3 adr held", {51'b0, wb_adr_o}, {51'b0, snap_adr});
      end
      if (resp_valid_o) begin
        chk("R4/R6 data", resp_data_o, memf(resp_addr_o[15:3]));
        resp_cyc[n_resp] = cyc_n;
        resp_adr[n_resp] = resp_addr_o;
        n_resp++;
      end
      if (snap_push) begin
        if (n_push % 8 == 0) begin
          grp_line  = snap_adr[12:3];
          grp_start = snap_adr[2:0];
        end else begin
          chk("R2 wrap order", {51'b0, snap_adr},
              {51'b0, grp_line, 3'(grp_start + 3'(n_push % 8))});
        end
        push_adr[n_push] = snap_adr;
        push_cyc[n_push] = cyc_n;
        n_push++;
        fq.push_back(snap_adr);
      end
      if ((n_pop % 8) != 0) chk("R2 cyc held", {63'b0, wb_cyc_o}, 64'd1);
    end
    wb_stall_i = rst_ni && stall_en && (cyc_n % 3 == 1);
    wb_ack_i   = rst_ni && (fq.size() > 0) && !(gap_en && (cyc_n % 3 != 0));
    wb_dat_i   = (fq.size() > 0) ? memf(fq[0]) : '0;
    #1;
    snap_ack  = wb_ack_i;
    snap_push = wb_cyc_o && wb_stb_o && !wb_stall_i;
    snap_hold = wb_stb_o && wb_stall_i;
    snap_adr  = wb_adr_o;
  endtask

  initial forever begin
    @(negedge clk_i);
    bus_step();
  end

  task automatic step();
    @(negedge clk_i);
    #2;
  endtask

  task automatic do_load(input logic [15:0] a, output int acc);
    req_addr_i  = a;
    req_valid_i = 1'b1;
    #1;
    while (!req_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    acc = cyc_n + 1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_resp(input int target);
    int t0 = cyc_n;
    while (n_resp < target && cyc_n - t0 < 3000) step();
    if (n_resp < target) chk("response timeout", 64'(n_resp), 64'(target));
  endtask

  task automatic wait_idle();
    step();
    while (wb_cyc_o || fq.size() > 0) step();
    step();
  endtask

  function automatic int find_resp(logic [15:0] a, int from);
    for (int i = n_resp - 1; i >= from; i--) if (resp_adr[i] == a) return i;
    return from;
  endfunction

  initial begin
    while (cyc_n < 100000) @(negedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc_n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int acc, base, r0, p, idx;
    logic [15:0] a, b;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 cyc idle", {63'b0, wb_cyc_o}, 64'd0);
    chk("R1 stb idle", {63'b0, wb_stb_o}, 64'd0);
    chk("R1 no resp", {63'b0, resp_valid_o}, 64'd0);
    chk("R1 ready", {63'b0, req_ready_o}, 64'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    chk("R1 ready after reset", {63'b0, req_ready_o}, 64'd1);
    chk("R1 cyc after reset", {63'b0, wb_cyc_o}, 64'd0);

    // every start row: miss, then hit sweep of the line
    for (int s = 0; s < 8; s++) begin
      stall_en = (s % 2 == 1);
      gap_en   = (s >= 4);
      victim_way_i = 1'(s / 4);
      a = mk(s + 1, s % 4, s, s);
      base = n_push; r0 = n_resp;
      do_load(a, acc);
      wait_resp(r0 + 1);
      chk("R2 first row", {61'b0, push_adr[base][2:0]}, 64'(s));
      chk("R4 resp addr", {48'b0, resp_adr[r0]}, {48'b0, a});
      chk("R4 resp cycle", 64'(resp_cyc[r0]), 64'(ack_log[base]));
      wait_idle();
      chk("R2 eight requests", 64'(n_push - base), 64'd8);
      for (int r = 0; r < 8; r++) begin
        p = n_push; r0 = n_resp;
        do_load(mk(s + 1, s % 4, r, 7 - r), acc);
        wait_resp(r0 + 1);
        chk("R6 hit latency", 64'(resp_cyc[r0]), 64'(acc + 1));
        chk("R6 no bus", 64'(n_push), 64'(p));
      end
    end

    // way replacement in set 0: tag 1 in way 0, tag 5 in way 1
    stall_en = 1; gap_en = 0;
    p = n_push;
    do_load(mk(1, 0, 3, 0), acc); wait_idle();
    do_load(mk(5, 0, 3, 0), acc); wait_idle();
    chk("R8 both ways resident", 64'(n_push), 64'(p));
    victim_way_i = 1'b0;
    do_load(mk(9, 0, 2, 0), acc); wait_idle();
    chk("R8 new line refilled", 64'(n_push - p), 64'd8);
    p = n_push;
    do_load(mk(5, 0, 6, 0), acc); wait_idle();
    chk("R8 other way kept", 64'(n_push), 64'(p));
    do_load(mk(1, 0, 6, 0), acc); wait_idle();
    chk("R8 victim evicted", 64'(n_push - p), 64'd8);

    // follower load at every row distance
    gap_en = 1;
    for (int k = 1; k < 8; k++) begin
      int s = (k * 3) % 8;
      victim_way_i = 1'(k % 2);
      stall_en = (k % 2 == 0);
      a = mk(40 + k, k % 4, s, 0);
      b = mk(40 + k, k % 4, (s + k) % 8, 1);
      base = n_push; r0 = n_resp;
      do_load(a, acc);
      do_load(b, acc);
      wait_resp(r0 + 2);
      wait_idle();
      idx = find_resp(b, r0);
      chk("R5 follower cycle", 64'(resp_cyc[idx]), 64'(ack_log[base + k] + 1));
      if (k < 7) chk("R5 before line end", 64'(resp_cyc[idx] < ack_log[base + 7]), 64'd1);
      chk("R5 no extra read", 64'(n_push - base), 64'd8);
    end

    // other-line miss during a refill waits for it
    victim_way_i = 1'b0;
    a = mk(60, 1, 2, 0);
    b = mk(61, 2, 6, 0);
    base = n_push; r0 = n_resp;
    do_load(a, acc);
    do_load(b, acc);
    wait_resp(r0 + 2);
    wait_idle();
    chk("R7 two refills", 64'(n_push - base), 64'd16);
    chk("R7 second start row", {61'b0, push_adr[base + 8][2:0]}, 64'd6);
    chk("R7 serialized", 64'(push_cyc[base + 8] > ack_log[base + 7]), 64'd1);
    idx = find_resp(b, r0);
    chk("R7 second resp cycle", 64'(resp_cyc[idx]), 64'(ack_log[base + 8]));

    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule